// File: doc/BRIEF.md
# Flag-Setting Integer ALU

This block is the arithmetic and logic stage of a register-to-register datapath. Each cycle it may accept one operation: a 4-bit operation code, a left operand, a right operand that has already been through the shifter, the current condition flags, the shifter's carry-out and a set-flags request. One clock later it presents the result, the four condition flags and a write-back enable for the register file.

There are sixteen operations. Eight are bitwise: AND, XOR, OR, move, move-inverted, bit-clear, and the AND and XOR probes. Eight use the adder: add, add-with-carry, subtract, reverse subtract, subtract-with-carry, reverse subtract-with-carry, and the subtract and add probes. The four probe codes (0x8 to 0xB) exist only to set flags. They never request a register write, and they update the flags whether or not set-flags is asserted.

The flag vector is packed as bit 3 = N, bit 2 = Z, bit 1 = C, bit 0 = V, on both the input and the output. Operations that chain a carry read it from bit 1 of the incoming flags.

Top module: `alu_flagcore`

## Requirements
- R1: On a synchronous active-high reset, out_valid, wr_en, result and flags_out all become zero.
- R2: The bitwise codes give these results: 0x0 and 0x8 give lhs AND rhs, 0x1 and 0x9 give lhs XOR rhs, 0xC gives lhs OR rhs, 0xD gives rhs, 0xE gives lhs AND NOT rhs, and 0xF gives NOT rhs.
- R3: The adder codes give these results, with c = flags_in[1]: 0x2 and 0xA give lhs-rhs, 0x3 gives rhs-lhs, 0x4 and 0xB give lhs+rhs, 0x5 gives lhs+rhs+c, 0x6 gives lhs-rhs-1+c, and 0x7 gives rhs-lhs-1+c. All results wrap to WIDTH bits.
- R4: When an adder operation updates the flags, the new C is the unsigned carry-out of the addition. For the subtracting forms this means C is 1 exactly when no borrow occurs.
- R5: When an adder operation updates the flags, the new V is 1 exactly when the true signed result does not fit in WIDTH bits.
- R6: When a bitwise operation updates the flags, the new C equals shift_carry and the new V equals flags_in[0].
- R7: Whenever flags update, the new N is the result's top bit and the new Z is 1 exactly when the result is zero.
- R8: Codes 0x8 to 0xB leave wr_en low and update the flags even when set_flags is low.
- R9: For codes 0x0 to 0x7 and 0xC to 0xF with set_flags low, flags_out equals flags_in.
- R10: Outputs appear one cycle after an accepted input, and out_valid follows in_valid. With in_valid low, the next cycle has out_valid and wr_en low while result and flags_out keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation present this cycle |
| op | input | 4 | Operation code |
| lhs | input | WIDTH | Left operand |
| rhs | input | WIDTH | Right operand, already shifted |
| flags_in | input | 4 | Current flags {N,Z,C,V} |
| shift_carry | input | 1 | Carry-out of the shifter |
| set_flags | input | 1 | Request a flag update |
| out_valid | output | 1 | Registered result valid |
| result | output | WIDTH | Registered result |
| flags_out | output | 4 | Registered flags {N,Z,C,V} |
| wr_en | output | 1 | Register write-back request |

## Verification
The bench builds the block with WIDTH = 32, its default. At this width the interesting cases sit at the operand values 0x0000_0000, 0x7FFF_FFFF, 0x8000_0000 and 0xFFFF_FFFF. Directed cases at those values cover signed overflow in both directions, carry-out with a zero result, and borrow versus no-borrow with either incoming carry. Random cases drive all sixteen codes with every combination of set-flags and incoming flags, and a 64-bit model predicts each result.

// File: rtl/alu_flagcore_pkg.sv
package alu_flagcore_pkg;

  typedef enum logic [3:0] {
    OP_AND = 4'h0, OP_XOR = 4'h1, OP_SUB = 4'h2, OP_RSB = 4'h3,
    OP_ADD = 4'h4, OP_ADC = 4'h5, OP_SBC = 4'h6, OP_RSC = 4'h7,
    OP_TST = 4'h8, OP_TEQ = 4'h9, OP_CMP = 4'hA, OP_CMN = 4'hB,
    OP_ORR = 4'hC, OP_MOV = 4'hD, OP_BIC = 4'hE, OP_MVN = 4'hF
  } alu_op_e;

  // Flag bit positions inside the 4-bit flag vector.
  localparam int FL_N = 3;
  localparam int FL_Z = 2;
  localparam int FL_C = 1;
  localparam int FL_V = 0;

  function automatic logic op_is_probe(input logic [3:0] code);
    return code[3:2] == 2'b10;
  endfunction

  function automatic logic op_uses_adder(input logic [3:0] code);
    return (code[3:2] == 2'b01) || (code[3:1] == 3'b001) || (code[3:1] == 3'b101);
  endfunction

endpackage

// File: rtl/alu_bitwise.sv
module alu_bitwise
  import alu_flagcore_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [3:0]       op,
  input  logic [WIDTH-1:0] lhs,
  input  logic [WIDTH-1:0] rhs,
  output logic [WIDTH-1:0] res
);
  always_comb begin
    unique case (op)
      OP_AND, OP_TST: res = lhs & rhs;
      OP_XOR, OP_TEQ: res = lhs ^ rhs;
      OP_ORR:         res = lhs | rhs;
      OP_MOV:         res = rhs;
      OP_BIC:         res = lhs & ~rhs;
      OP_MVN:         res = ~rhs;
      default:        res = '0;
    endcase
  end
endmodule

// File: rtl/alu_addsub.sv
module alu_addsub
  import alu_flagcore_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [3:0]       op,
  input  logic [WIDTH-1:0] lhs,
  input  logic [WIDTH-1:0] rhs,
  input  logic             cin,
  output logic [WIDTH-1:0] sum,
  output logic             cout,
  output logic             ovf
);
  localparam int SW = WIDTH + 1;

  logic [WIDTH-1:0] opa, opb;
  logic             c0;
  logic [SW-1:0]    total;

  // Every form is mapped onto a single adder: a + b + c0.
  always_comb begin
    opa = lhs;
    opb = rhs;
    c0  = 1'b0;
    unique case (op)
      OP_SUB, OP_CMP: begin opa = lhs; opb = ~rhs; c0 = 1'b1; end
      OP_RSB:         begin opa = rhs; opb = ~lhs; c0 = 1'b1; end
      OP_ADD, OP_CMN: begin opa = lhs; opb = rhs;  c0 = 1'b0; end
      OP_ADC:         begin opa = lhs; opb = rhs;  c0 = cin;  end
      OP_SBC:         begin opa = lhs; opb = ~rhs; c0 = cin;  end
      OP_RSC:         begin opa = rhs; opb = ~lhs; c0 = cin;  end
      default:        begin opa = lhs; opb = rhs;  c0 = 1'b0; end
    endcase
  end

  assign total = {1'b0, opa} + {1'b0, opb} + {{WIDTH{1'b0}}, c0};
  assign sum   = total[WIDTH-1:0];
  assign cout  = total[WIDTH];
  assign ovf   = (opa[WIDTH-1] == opb[WIDTH-1]) && (total[WIDTH-1] != opa[WIDTH-1]);
endmodule

// File: rtl/alu_flagcore.sv
module alu_flagcore
  import alu_flagcore_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [3:0]       op,
  input  logic [WIDTH-1:0] lhs,
  input  logic [WIDTH-1:0] rhs,
  input  logic [3:0]       flags_in,
  input  logic             shift_carry,
  input  logic             set_flags,
  output logic             out_valid,
  output logic [WIDTH-1:0] result,
  output logic [3:0]       flags_out,
  output logic             wr_en
);
  logic [WIDTH-1:0] logic_res, arith_res, next_res;
  logic             arith_c, arith_v, is_arith, is_probe, upd;
  logic [3:0]       next_flags;

  alu_bitwise #(.WIDTH(WIDTH)) u_bitwise (
    .op(op), .lhs(lhs), .rhs(rhs), .res(logic_res)
  );

  alu_addsub #(.WIDTH(WIDTH)) u_addsub (
    .op(op), .lhs(lhs), .rhs(rhs), .cin(flags_in[FL_C]),
    .sum(arith_res), .cout(arith_c), .ovf(arith_v)
  );

  assign is_arith = op_uses_adder(op);
  assign is_probe = op_is_probe(op);
  assign upd      = set_flags || is_probe;
  assign next_res = is_arith ? arith_res : logic_res;

  always_comb begin
    next_flags = flags_in;
    if (upd) begin
      next_flags[FL_N] = next_res[WIDTH-1];
      next_flags[FL_Z] = (next_res == '0);
      next_flags[FL_C] = is_arith ? arith_c : shift_carry;
      next_flags[FL_V] = is_arith ? arith_v : flags_in[FL_V];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      wr_en     <= 1'b0;
      result    <= '0;
      flags_out <= '0;
    end else begin
      out_valid <= in_valid;
      wr_en     <= in_valid && !is_probe;
      if (in_valid) begin
        result    <= next_res;
        flags_out <= next_flags;
      end
    end
  end

  AST_PROBE_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    in_valid && op[3:2] == 2'b10 |=> !wr_en) else $error("probe wrote"); // R8
  AST_FLAGS_KEPT: assert property (@(posedge clk) disable iff (rst)
    in_valid && !set_flags && op[3:2] != 2'b10 |=> flags_out == $past(flags_in)) else $error("flags moved"); // R9
  AST_LOGIC_V_KEPT: assert property (@(posedge clk) disable iff (rst)
    in_valid && (set_flags || op[3:2] == 2'b10) && !op_uses_adder(op)
    |=> flags_out[FL_V] == $past(flags_in[FL_V])) else $error("V moved"); // R6
  AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (rst)
    in_valid && (set_flags || op[3:2] == 2'b10) |=> flags_out[FL_Z] == (result == '0)) else $error("Z wrong"); // R7
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid && !wr_en && $stable(result) && $stable(flags_out)) else $error("idle moved"); // R10
  AST_VALID_FOLLOW: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid) else $error("valid lost"); // R10
endmodule

// File: tb/alu_flagcore_tb.sv
module alu_flagcore_tb;
  localparam int W = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [3:0] op = '0;
  logic [W-1:0] lhs = '0, rhs = '0;
  logic [3:0] flags_in = '0;
  logic shift_carry = 1'b0, set_flags = 1'b0;
  logic out_valid, wr_en;
  logic [W-1:0] result;
  logic [3:0] flags_out;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  alu_flagcore #(.WIDTH(W)) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op(op), .lhs(lhs), .rhs(rhs),
    .flags_in(flags_in), .shift_carry(shift_carry), .set_flags(set_flags),
    .out_valid(out_valid), .result(result), .flags_out(flags_out), .wr_en(wr_en)
  );

  task automatic chk(input string tag, input longint got, input longint exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  // Independent model using 64-bit integer arithmetic.
  function automatic void model(input logic [3:0] c, input logic [W-1:0] a, input logic [W-1:0] b,
                                input logic [3:0] fin, input logic sc, input logic sf,
                                output logic [W-1:0] r, output logic [3:0] f, output logic we);
    longint ua = longint'({32'b0, a});
    longint ub = longint'({32'b0, b});
    longint sa = longint'($signed(a));
    longint sb = longint'($signed(b));
    longint cc = longint'(fin[1]);
    longint ut = 0, st = 0;
    bit arith = 1'b1, sub = 1'b0;
    case (c)
      4'h0, 4'h8: begin arith = 0; r = a & b; end
      4'h1, 4'h9: begin arith = 0; r = a ^ b; end
      4'hC: begin arith = 0; r = a | b; end
      4'hD: begin arith = 0; r = b; end
      4'hE: begin arith = 0; r = a & ~b; end
      4'hF: begin arith = 0; r = ~b; end
      4'h2, 4'hA: begin sub = 1; ut = ua - ub; st = sa - sb; end
      4'h3: begin sub = 1; ut = ub - ua; st = sb - sa; end
      4'h4, 4'hB: begin ut = ua + ub; st = sa + sb; end
      4'h5: begin ut = ua + ub + cc; st = sa + sb + cc; end
      4'h6: begin sub = 1; ut = ua - ub - 1 + cc; st = sa - sb - 1 + cc; end
      default: begin sub = 1; ut = ub - ua - 1 + cc; st = sb - sa - 1 + cc; end
    endcase
    if (arith) r = ut[W-1:0];
    we = (c[3:2] != 2'b10);
    f = fin;
    if (sf || c[3:2] == 2'b10) begin
      f[3] = r[W-1];
      f[2] = (r == '0);
      if (arith) begin
        f[1] = sub ? (ut >= 0) : (ut > longint'(32'hFFFF_FFFF));
        f[0] = (st > 64'sd2147483647) || (st < -64'sd2147483648);
      end else begin
        f[1] = sc;
      end
    end
  endfunction

  // Drive at a falling edge, check at the next falling edge (one register stage).
  task automatic run(input logic [3:0] c, input logic [W-1:0] a, input logic [W-1:0] b,
                     input logic [3:0] fin, input logic sc, input logic sf);
    logic [W-1:0] er; logic [3:0] ef; logic ew;
    bit arith;
    op = c; lhs = a; rhs = b; flags_in = fin; shift_carry = sc; set_flags = sf; in_valid = 1'b1;
    model(c, a, b, fin, sc, sf, er, ef, ew);
    arith = !(c inside {4'h0, 4'h1, 4'h8, 4'h9, 4'hC, 4'hD, 4'hE, 4'hF});
    @(negedge clk);
    chk("R10 out_valid", longint'(out_valid), 1);
    chk(arith ? "R3 result" : "R2 result", longint'(result), longint'(er));
    chk(c[3:2] == 2'b10 ? "R8 wr_en" : "R10 wr_en", longint'(wr_en), longint'(ew));
    if (!(sf || c[3:2] == 2'b10)) chk("R9 flags", longint'(flags_out), longint'(ef));
    else begin
      chk("R7 NZ", longint'(flags_out[3:2]), longint'(ef[3:2]));
      if (arith) begin
        chk("R4 C", longint'(flags_out[1]), longint'(ef[1]));
        chk("R5 V", longint'(flags_out[0]), longint'(ef[0]));
      end else
        chk("R6 CV", longint'(flags_out[1:0]), longint'(ef[1:0]));
    end
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] prev_r; logic [3:0] prev_f;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 out_valid", longint'(out_valid), 0);
    chk("R1 wr_en", longint'(wr_en), 0);
    chk("R1 result", longint'(result), 0);
    chk("R1 flags", longint'(flags_out), 0);
    rst = 1'b0;

    // Directed corners
    run(4'h4, 32'h7FFF_FFFF, 32'h1, 4'h0, 0, 1);          // R5 positive overflow
    run(4'h4, 32'hFFFF_FFFF, 32'h1, 4'h0, 0, 1);          // R4 carry, R7 Z
    run(4'h2, 32'h0, 32'h1, 4'h0, 0, 1);                  // R4 borrow -> C=0
    run(4'h2, 32'h8000_0000, 32'h1, 4'h0, 0, 1);          // R5 negative overflow
    run(4'h3, 32'h5, 32'h3, 4'h0, 0, 1);                  // R3 reverse
    run(4'h6, 32'h10, 32'h10, 4'h0, 0, 1);                // R3 SBC with C=0
    run(4'h6, 32'h10, 32'h10, 4'h2, 0, 1);                // R3 SBC with C=1
    run(4'h7, 32'h1, 32'h0, 4'h2, 0, 1);                  // R3 RSC
    run(4'h5, 32'hFFFF_FFFF, 32'h0, 4'h2, 0, 1);          // R3 ADC wrap
    run(4'h8, 32'hF0F0_F0F0, 32'h0F0F_0F0F, 4'h1, 1, 0);  // R8 probe, R6 V kept
    run(4'hA, 32'h5, 32'h5, 4'h0, 0, 0);                  // R8 compare equal
    run(4'hB, 32'h8000_0000, 32'h8000_0000, 4'h0, 0, 0);  // R8 add probe overflow
    run(4'hD, 32'h0, 32'h8000_0000, 4'h1, 1, 1);          // R6 move, shifter carry
    run(4'hF, 32'h0, 32'hFFFF_FFFF, 4'h0, 0, 1);          // R2 MVN zero
    run(4'hE, 32'hFFFF_FFFF, 32'h0000_FFFF, 4'hF, 0, 0);  // R9 flags kept
    run(4'h4, 32'h7FFF_FFFF, 32'h1, 4'h5, 0, 0);          // R9 arithmetic, no update

    // R10 idle: outputs held, no valid or write
    prev_r = result; prev_f = flags_out;
    in_valid = 1'b0; op = 4'h4; lhs = 32'h1234; rhs = 32'h1; set_flags = 1'b1;
    @(negedge clk);
    chk("R10 idle valid", longint'(out_valid), 0);
    chk("R10 idle wr_en", longint'(wr_en), 0);
    chk("R10 idle result", longint'(result), longint'(prev_r));
    chk("R10 idle flags", longint'(flags_out), longint'(prev_f));

    // Random back-to-back traffic
    for (int i = 0; i < 3000; i++) begin
      logic [W-1:0] a, b;
      int pick = $urandom_range(0, 7);
      a = $urandom; b = $urandom;
      if (pick == 0) a = 32'h8000_0000;
      if (pick == 1) b = 32'h7FFF_FFFF;
      if (pick == 2) b = a;
      if (pick == 3) a = 32'hFFFF_FFFF;
      run(4'($urandom), a, b, 4'($urandom), 1'($urandom), 1'($urandom));
    end

    in_valid = 1'b0;
    @(negedge clk);
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule